// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between an internal valid/ready request bus and an external asynchronous 64K x 16 static RAM. It accepts one single-beat access at a time (a word, the low byte or the high byte, read or write) and turns it into the active-low chip select, write enable, output enable and per-lane byte enable waveforms the RAM expects. It drives the address and a shared 16-bit data bus with a separate drive-enable, captures read data at the end of the access window, and returns it with a one-cycle response strobe.

Every timing interval (write pulse, write recovery, read access, bus turnaround) is a parameter holding a cycle count, rounded up from the RAM's nanosecond figures at the chosen clock. At a 10 ns clock the defaults give a 6-cycle write pulse, one recovery cycle for data hold (7-cycle write in total), a 7-cycle read access and one turnaround cycle after every read. Output enable stays high for the whole of a write, so the write pulse never has to cover the RAM's output turn-off time. A request whose byte mask is zero completes without any RAM activity.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While rst_ni is low and after reset, req_ready_o is 1, rsp_valid_o is 0, ram_cs_no, ram_we_no and ram_oe_no are 1, both bits of ram_be_no are 1 and ram_dq_oe_o is 0.
- R2: A write with mask M holds ram_cs_no and ram_we_no low for exactly WR_PULSE_CYC (6) cycles, with ram_be_no = ~M (bit 0 low byte, data bits 7:0; bit 1 high byte, bits 15:8) and ram_oe_no high throughout.
- R3: Write data is driven, unchanged, from the first strobe cycle through WR_RECOV_CYC (1) cycle after the strobes rise.
- R4: ram_addr_o does not change between two consecutive cycles in which the RAM is selected.
- R5: A read holds ram_cs_no and ram_oe_no low with ram_we_no high for exactly RD_ACC_CYC (7) cycles, with ram_be_no = ~M, and samples the bus at the end of that window.
- R6: A read response is a single-cycle rsp_valid_o pulse in the cycle after capture (8 cycles after acceptance); lanes not in the mask return zero.
- R7: The controller never drives the bus while ram_oe_no is low, and after a read at least TURN_CYC (1) cycle passes with neither side driving before the controller drives again.
- R8: A request with mask 00 does not select the RAM, leaves memory unchanged, and is answered in the next cycle with rsp_rdata_o = 0.
- R9: req_ready_o is 1 only while no access is in progress; each accepted request yields exactly one response.
- R10: A write response pulses in the last recovery cycle, WR_PULSE_CYC + WR_RECOV_CYC (7) cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request accepted when valid |
| req_addr_i | input | 16 | Word address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 2 | Byte mask, bit 0 low byte, bit 1 high byte |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-cycle completion strobe |
| rsp_rdata_o | output | 16 | Read data, masked lanes zero |
| ram_addr_o | output | 16 | RAM address |
| ram_cs_no | output | 1 | RAM chip select, active low |
| ram_we_no | output | 1 | RAM write enable, active low |
| ram_oe_no | output | 1 | RAM output enable, active low |
| ram_be_no | output | 2 | RAM byte enables, active low, bit 0 low byte |
| ram_dq_o | output | 16 | Data driven toward the RAM |
| ram_dq_oe_o | output | 1 | Drive enable for ram_dq_o |
| ram_dq_i | input | 16 | Data received from the RAM |

## Verification
The assertions assume the requester holds a request stable until it is accepted and that ram_dq_i carries whatever the RAM drives, valid or not; they make no assumption about the data values. The bench presents each request only while it is idle-side, drops valid right after acceptance, and uses a RAM model that returns garbage until the full access window has elapsed and on unselected lanes, so early sampling or unmasked lanes show up as data mismatches. The model also flags address movement during an active select, short or long strobes, write data that is not stable from strobe start through hold, and any overlap of the two bus drivers.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WREC,
    ST_RD,
    ST_TURN,
    ST_DONE
  } ctl_state_e;
endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
  parameter int LANES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               capture_i,
  input  logic [LANES-1:0]   lane_en_i,
  input  logic [8*LANES-1:0] dq_i,
  output logic [8*LANES-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lane_q <= '0;
      else if (clear_i)   lane_q <= '0;
      else if (capture_i) lane_q <= lane_en_i[l] ? dq_i[8*l +: 8] : 8'h00;
    end
    assign rdata_o[8*l +: 8] = lane_q;
  end
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_lane_pkg::*;
#(
  parameter int LANES = 2
) (
  input  ctl_state_e       state_i,
  input  logic [LANES-1:0] be_i,
  output logic             cs_no,
  output logic             we_no,
  output logic             oe_no,
  output logic [LANES-1:0] be_no,
  output logic             dq_oe_o
);
  logic wr_phase, rd_phase;

  assign wr_phase = (state_i == ST_WR);
  assign rd_phase = (state_i == ST_RD);

  assign cs_no   = ~(wr_phase | rd_phase);
  assign we_no   = ~wr_phase;
  assign oe_no   = ~rd_phase;  // held high for all write states
  assign be_no   = (wr_phase | rd_phase) ? ~be_i : '1;
  assign dq_oe_o = wr_phase | (state_i == ST_WREC);  // recovery covers data hold
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int LANES        = 2,
  parameter int WR_PULSE_CYC = 6,
  parameter int WR_RECOV_CYC = 1,
  parameter int RD_ACC_CYC   = 7,
  parameter int TURN_CYC     = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_we_i,
  input  logic [LANES-1:0]   req_be_i,
  input  logic [8*LANES-1:0] req_wdata_i,
  output logic               rsp_valid_o,
  output logic [8*LANES-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0]  ram_addr_o,
  output logic               ram_cs_no,
  output logic               ram_we_no,
  output logic               ram_oe_no,
  output logic [LANES-1:0]   ram_be_no,
  output logic [8*LANES-1:0] ram_dq_o,
  output logic               ram_dq_oe_o,
  input  logic [8*LANES-1:0] ram_dq_i
);
  localparam int DATA_W  = 8 * LANES;
  localparam int MAX_A   = (WR_PULSE_CYC > RD_ACC_CYC) ? WR_PULSE_CYC : RD_ACC_CYC;
  localparam int MAX_B   = (WR_RECOV_CYC > TURN_CYC) ? WR_RECOV_CYC : TURN_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] LD_WR   = CNT_W'(WR_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WREC = CNT_W'(WR_RECOV_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_ACC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);

  ctl_state_e         state_q, state_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [LANES-1:0]   be_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               turn_first_q;
  logic               accept, t_load, t_done, capture, clear;
  logic [CNT_W-1:0]   t_val;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i & req_ready_o;

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    capture = 1'b0;
    clear   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (req_be_i == '0) begin
          state_d = ST_DONE;
          clear   = 1'b1;
        end else if (req_we_i) begin
          state_d = ST_WR;
          t_load  = 1'b1;
          t_val   = LD_WR;
        end else begin
          state_d = ST_RD;
          t_load  = 1'b1;
          t_val   = LD_RD;
        end
      end
      ST_WR: if (t_done) begin
        state_d = ST_WREC;
        t_load  = 1'b1;
        t_val   = LD_WREC;
      end
      ST_WREC: if (t_done) state_d = ST_IDLE;
      ST_RD: if (t_done) begin
        state_d = ST_TURN;
        t_load  = 1'b1;
        t_val   = LD_TURN;
        capture = 1'b1;
      end
      ST_TURN: if (t_done) state_d = ST_IDLE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      be_q         <= '0;
      wdata_q      <= '0;
      turn_first_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      turn_first_q <= capture;
      if (accept) begin  // address moves only out of an idle (deselected) cycle
        addr_q  <= req_addr_i;
        be_q    <= req_be_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .done_o     (t_done)
  );

  sram_lane_capture #(.LANES(LANES)) u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .capture_i (capture),
    .lane_en_i (be_q),
    .dq_i      (ram_dq_i),
    .rdata_o   (rsp_rdata_o)
  );

  sram_strobe_gen #(.LANES(LANES)) u_strobe (
    .state_i (state_q),
    .be_i    (be_q),
    .cs_no   (ram_cs_no),
    .we_no   (ram_we_no),
    .oe_no   (ram_oe_no),
    .be_no   (ram_be_no),
    .dq_oe_o (ram_dq_oe_o)
  );

  assign ram_addr_o  = addr_q;
  assign ram_dq_o    = wdata_q;
  assign rsp_valid_o = (state_q == ST_DONE) | (state_q == ST_WREC && t_done)
                     | (state_q == ST_TURN && turn_first_q);
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [LANES-1:0]   req_be_i,
  input logic               rsp_valid_o,
  input logic [ADDR_W-1:0]  ram_addr_o,
  input logic               ram_cs_no,
  input logic               ram_we_no,
  input logic               ram_oe_no,
  input logic [8*LANES-1:0] ram_dq_o,
  input logic               ram_dq_oe_o
);
  assert_wr_oe_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_cs_no && !ram_we_no) |-> ram_oe_no);

  assert_wdata_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_no && !$past(ram_we_no)) |-> (ram_dq_oe_o && $stable(ram_dq_o)));

  assert_addr_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_cs_no && !$past(ram_cs_no)) |-> $stable(ram_addr_o));

  assert_rsp_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_no_drive_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_no |-> !ram_dq_oe_o);

  assert_turn_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(ram_oe_no)) |-> !ram_dq_oe_o);

  assert_zero_mask_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_be_i == '0) |=> ram_cs_no);

  assert_ready_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ram_cs_no && !ram_dq_oe_o && !rsp_valid_o));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_be_i    (req_be_i),
  .rsp_valid_o (rsp_valid_o),
  .ram_addr_o  (ram_addr_o),
  .ram_cs_no   (ram_cs_no),
  .ram_we_no   (ram_we_no),
  .ram_oe_no   (ram_oe_no),
  .ram_dq_o    (ram_dq_o),
  .ram_dq_oe_o (ram_dq_oe_o)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam int WP = 6, WREC = 1, RA = 7, TURN = 1;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [15:0] req_addr_i = '0, req_wdata_i = '0;
  logic [1:0]  req_be_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [15:0] rsp_rdata_o, ram_addr_o, ram_dq_o, ram_dq_i;
  logic        ram_cs_no, ram_we_no, ram_oe_no, ram_dq_oe_o;
  logic [1:0]  ram_be_no;

  sram_lane_ctrl u_sram_lane_ctrl (.*);

  always #(CLK_NS/2) clk_i = ~clk_i;

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // RAM model: 256 words, aliased on the low address byte
  logic [15:0] mem [256];
  logic        wr_act, rd_act, p_wr, p_rd, p_dq_oe;
  logic [15:0] p_addr, p_dq;
  logic [1:0]  p_be;
  int wcnt = 0, rcnt = 0, dstab = 0, since_rd = 100;
  int v_addr = 0, v_wp = 0, v_wd = 0, v_rp = 0, v_bus = 0, v_oe = 0, v_turn = 0;

  assign wr_act = !ram_cs_no && !ram_we_no && (ram_be_no != 2'b11);
  assign rd_act = !ram_cs_no && ram_we_no && !ram_oe_no && (ram_be_no != 2'b11);
  assign ram_dq_i = (rd_act && rcnt >= RA)
      ? {(!ram_be_no[1] ? mem[ram_addr_o[7:0]][15:8] : 8'hA5),
         (!ram_be_no[0] ? mem[ram_addr_o[7:0]][7:0]  : 8'h5A)}
      : 16'hBAD0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    p_wr = 0; p_rd = 0; p_dq_oe = 0; p_addr = '0; p_dq = '0; p_be = 2'b11;
  end

  always @(negedge clk_i) if (rst_ni) begin
    if ((wr_act || rd_act) && (p_wr || p_rd) && ram_addr_o != p_addr) v_addr++;
    if (wr_act && !ram_oe_no) v_oe++;
    if (rd_act && ram_dq_oe_o) v_bus++;
    if (ram_dq_oe_o && since_rd < TURN) v_turn++;
    if (ram_dq_oe_o) dstab = (p_dq_oe && ram_dq_o == p_dq) ? dstab + 1 : 1;
    else dstab = 0;
    if (wr_act) wcnt++;
    else if (p_wr) begin
      if (wcnt != WP) v_wp++;
      if (!ram_dq_oe_o || dstab < WP + 1) v_wd++;
      if (!p_be[0]) mem[p_addr[7:0]][7:0]  = p_dq[7:0];
      if (!p_be[1]) mem[p_addr[7:0]][15:8] = p_dq[15:8];
      wcnt = 0;
    end
    if (rd_act) begin rcnt++; since_rd = 0; end
    else begin
      if (p_rd && rcnt != RA) v_rp++;
      rcnt = 0;
      if (!ram_dq_oe_o && since_rd < 100) since_rd++;
    end
    p_wr = wr_act; p_rd = rd_act; p_addr = ram_addr_o; p_be = ram_be_no;
    p_dq = ram_dq_o; p_dq_oe = ram_dq_oe_o;
  end

  logic        first_ready, first_cs;
  logic [15:0] got_rdata;
  int          got_lat;

  task automatic do_req(input logic we, input logic [1:0] be,
                        input logic [15:0] addr, input logic [15:0] wd);
    @(negedge clk_i);
    req_valid_i = 1; req_we_i = we; req_be_i = be; req_addr_i = addr; req_wdata_i = wd;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 0;
    first_ready = req_ready_o; first_cs = ram_cs_no;
    got_lat = 1;
    while (!rsp_valid_o && got_lat < 50) begin @(negedge clk_i); got_lat++; end
    got_rdata = rsp_rdata_o;
  endtask

  // {we, be[1:0], addr[15:0], wdata[15:0], exp_rdata[15:0]}
  localparam logic [50:0] VEC [12] = '{
    {1'b1, 2'b11, 16'h0010, 16'hA1B2, 16'h0000},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'hA1B2},
    {1'b1, 2'b01, 16'h0010, 16'hFF55, 16'h0000},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'hA155},
    {1'b1, 2'b10, 16'h0010, 16'h66FF, 16'h0000},
    {1'b0, 2'b10, 16'h0010, 16'h0000, 16'h6600},
    {1'b0, 2'b01, 16'h0010, 16'h0000, 16'h0055},
    {1'b1, 2'b11, 16'hFFFF, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 16'hFFFF, 16'h0000, 16'h1234},
    {1'b1, 2'b00, 16'h0010, 16'h0000, 16'h0000},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h6655},
    {1'b0, 2'b00, 16'h0020, 16'h0000, 16'h0000}
  };

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 3 + 1);
    // R1 during reset
    check("R1 reset strobes", {ram_cs_no, ram_we_no, ram_oe_no, ram_be_no, ram_dq_oe_o},
          {3'b111, 2'b11, 1'b0});
    check("R1 reset handshake", {req_ready_o, rsp_valid_o}, 2'b10);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    check("R1 after reset", {req_ready_o, rsp_valid_o, ram_cs_no, ram_dq_oe_o}, 4'b1010);

    for (int i = 0; i < 12; i++) begin
      logic vwe; logic [1:0] vbe; int exp_lat;
      vwe = VEC[i][50]; vbe = VEC[i][49:48];
      do_req(vwe, vbe, VEC[i][47:32], VEC[i][31:16]);
      exp_lat = (vbe == 2'b00) ? 1 : (vwe ? WP + WREC : RA + 1);
      if (vbe == 2'b00) begin
        check("R8 zero mask latency", got_lat, exp_lat);
        check("R8 zero mask rdata", got_rdata, 16'h0000);
        check("R8 zero mask no select", first_cs, 1'b1);
      end else if (vwe) begin
        check("R10 write latency", got_lat, exp_lat);
      end else begin
        check("R6 read latency", got_lat, exp_lat);
        check("R6 read data lanes", got_rdata, VEC[i][15:0]);
      end
      check("R9 not ready while busy", first_ready, 1'b0);
      @(negedge clk_i);
      check("R9 single response", rsp_valid_o, 1'b0);
    end

    // back-to-back read then write then read on another address
    do_req(1'b0, 2'b11, 16'h0010, 16'h0);
    do_req(1'b1, 2'b11, 16'h0042, 16'hC3C3);
    do_req(1'b0, 2'b11, 16'h0042, 16'h0);
    check("R5 read after write", got_rdata, 16'hC3C3);

    repeat (3) @(negedge clk_i);
    check("R4 address moved under select", v_addr, 0);
    check("R2 write pulse length", v_wp, 0);
    check("R2 output enable during write", v_oe, 0);
    check("R3 write data setup/hold", v_wd, 0);
    check("R5 read strobe length", v_rp, 0);
    check("R7 bus contention", v_bus, 0);
    check("R7 turnaround gap", v_turn, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule